// File: doc/BRIEF.md
# Biphase-mark subframe transmitter

The block turns a stream of stereo 16-bit PCM pairs into a single-wire digital audio line in the IEC 60958 consumer style. Each pair becomes two subframes, left first, then right. A subframe holds a synchronisation preamble, an auxiliary field, the audio word sent least significant bit first, and four flag bits. Every bit is sent as two line cells in biphase-mark code. One line cell goes out for each pulse of a cell-rate strobe, so one stereo frame takes 128 strobes.

Pairs arrive through a valid/ready handshake into a one-entry slot. The slot is emptied only when a left subframe begins. If the slot is empty at that point, the block sends zero audio marked invalid and does not stall the line. A mute input marks subframes invalid without changing the audio bits. The first auxiliary bit is used as parity compensation, so the transmitted parity flag is always zero. Because of this the line always sits low at a subframe boundary, and the three preambles can be sent as fixed cell patterns.

Top module: `spdif_tx`

## Requirements
- R1: `line_out` changes only in the clock cycle that follows a cycle with `cell_en` high. Each strobe emits exactly one cell, and a subframe is 64 strobes long.
- R2: Bit layout of a subframe, counted in bit periods of two cells: periods 0-3 are the preamble; period 4 is the parity-compensation bit; periods 5-11 are zero; periods 12-27 carry the 16-bit sample, least significant bit first; period 28 is V; periods 29 (U), 30 (C) and 31 (P) are zero. The left sample is sent in the subframe before the right sample.
- R3: The preamble occupies the first 8 cells and is sent most significant bit first: B = 11101000, M = 11100010, W = 11100100. Left subframes use M (or B, see R4). Right subframes use W.
- R4: The first subframe after reset uses preamble B. After that, every 384th subframe (every 192 stereo frames) uses B.
- R5: In cells 8 to 63, the first cell of every bit period is the inverse of the cell before it. The second cell is inverted again for a 1 and repeated for a 0.
- R6: The number of ones in bit periods 4 to 30 is even and P is 0. The line is therefore low in the last cell of every subframe.
- R7: When `mute` is high on the strobe that begins a subframe, that subframe carries V = 1. Its sample bits are unchanged.
- R8: When no pair is held at the strobe that begins a left subframe, both subframes of that frame carry a zero sample with V = 1.
- R9: A synchronous active-high `rst` drives `line_out` to 0 and empties the slot, so `in_ready` is 1. The next subframe starts at cell 0 with preamble B.
- R10: `in_ready` is high exactly when the slot is empty. A pair is accepted on a clock where `in_valid` and `in_ready` are both high, and `in_ready` is low on the following cycle. The pair is sent in the frame that begins at the first left-subframe start strobe after the acceptance cycle. A start strobe in the acceptance cycle itself does not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cell_en | input | 1 | Line cell strobe, one pulse per output cell |
| in_valid | input | 1 | A sample pair is offered |
| in_ready | output | 1 | Slot empty, pair will be accepted |
| in_left | input | 16 | Left channel sample |
| in_right | input | 16 | Right channel sample |
| mute | input | 1 | Mark subframes invalid |
| line_out | output | 1 | Biphase-mark encoded line |

## Verification
A wrong cell or subframe counter shows up at once on the line. A preamble lands off its 8-cell boundary, or a right-channel W pattern appears where M or B is due. Both are visible within one subframe (64 strobes). A block counter with the wrong modulus moves the B preamble and is caught at the next block start, at most 384 subframes later. A wrong polarity register or a wrong parity bit breaks the low-at-boundary rule and the bit-start transitions within the same subframe. A slot that is not cleared shows as `in_ready` stuck low, or as a pair sent twice in consecutive frames.

// File: rtl/spdif_pkg.sv
package spdif_pkg;

    localparam int SAMPLE_W     = 16;
    localparam int BITS_PER_SF  = 32;
    localparam int CELLS_PER_SF = 2 * BITS_PER_SF;
    localparam int POS_W        = $clog2(CELLS_PER_SF);
    localparam int BIT_IDX_W    = $clog2(BITS_PER_SF);
    localparam int PRE_CELLS    = 8;
    localparam int PRE_IDX_W    = $clog2(PRE_CELLS);

    // bit-period positions inside a subframe
    localparam int AUX_PARITY   = 4;
    localparam int AUDIO_LO     = BITS_PER_SF - 4 - SAMPLE_W;
    localparam int FLAG_V       = BITS_PER_SF - 4;

    typedef enum logic [1:0] {
        PRE_B = 2'd0,
        PRE_M = 2'd1,
        PRE_W = 2'd2
    } pre_kind_e;

    typedef struct packed {
        logic [SAMPLE_W-1:0] right;
        logic [SAMPLE_W-1:0] left;
    } pair_t;

    typedef struct packed {
        logic [SAMPLE_W-1:0] pcm;
        logic                invalid;
    } sf_payload_t;

    // fixed preamble cells, first cell in the MSB
    function automatic logic [PRE_CELLS-1:0] preamble_cells(input pre_kind_e kind);
        case (kind)
            PRE_B:   return 8'b1110_1000;
            PRE_M:   return 8'b1110_0010;
            PRE_W:   return 8'b1110_0100;
            default: return 8'b1110_0010;
        endcase
    endfunction

    // bit value per bit period; bit 4 makes the parity of 4..30 even
    function automatic logic [BITS_PER_SF-1:0] pack_bits(input sf_payload_t pl);
        logic [BITS_PER_SF-1:0] w;
        w = '0;
        for (int i = 0; i < SAMPLE_W; i++) begin
            w[AUDIO_LO+i] = pl.pcm[i];
        end
        w[FLAG_V]     = pl.invalid;
        w[AUX_PARITY] = (^pl.pcm) ^ pl.invalid;
        return w;
    endfunction

endpackage

// File: rtl/spdif_input_slot.sv
module spdif_input_slot
    import spdif_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    output logic  in_ready,
    input  pair_t in_pair,
    input  logic  take,
    output pair_t slot_pair,
    output logic  slot_full
);

    pair_t held_q;
    logic  full_q;

    assign in_ready  = !full_q;
    assign slot_pair = held_q;
    assign slot_full = full_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
            held_q <= '0;
        end else begin
            if (take) begin
                full_q <= 1'b0;
            end
            if (in_valid && !full_q) begin
                full_q <= 1'b1;
                held_q <= in_pair;
            end
        end
    end

endmodule

// File: rtl/spdif_frame_ctl.sv
module spdif_frame_ctl
    import spdif_pkg::*;
#(
    parameter int BLOCK_SUBFRAMES = 384
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cell_en,
    output logic [POS_W-1:0] pos,
    output logic             right_ch,
    output pre_kind_e        kind,
    output logic             sf_start,
    output logic             frame_start
);

    localparam int CNT_W = $clog2(BLOCK_SUBFRAMES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BLOCK_SUBFRAMES - 1);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(CELLS_PER_SF - 1);

    logic [POS_W-1:0] pos_q;
    logic             ch_q;
    logic [CNT_W-1:0] sf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
            ch_q  <= 1'b0;
            sf_q  <= '0;
        end else if (cell_en) begin
            if (pos_q == POS_LAST) begin
                pos_q <= '0;
                ch_q  <= !ch_q;
                sf_q  <= (sf_q == CNT_LAST) ? '0 : sf_q + 1'b1;
            end else begin
                pos_q <= pos_q + 1'b1;
            end
        end
    end

    always_comb begin
        if (sf_q == '0) begin
            kind = PRE_B;
        end else if (ch_q) begin
            kind = PRE_W;
        end else begin
            kind = PRE_M;
        end
    end

    assign pos         = pos_q;
    assign right_ch    = ch_q;
    assign sf_start    = cell_en && (pos_q == '0);
    assign frame_start = sf_start && !ch_q;

endmodule

// File: rtl/spdif_cell_enc.sv
module spdif_cell_enc
    import spdif_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cell_en,
    input  logic [POS_W-1:0]       pos,
    input  pre_kind_e              kind,
    input  logic [BITS_PER_SF-1:0] bits,
    output logic                   line
);

    logic                 line_q;
    logic [PRE_CELLS-1:0] pre;
    logic [PRE_IDX_W-1:0] pre_idx;
    logic [BIT_IDX_W-1:0] bit_idx;
    logic                 in_preamble;

    assign pre         = preamble_cells(kind);
    assign pre_idx     = PRE_IDX_W'(PRE_CELLS - 1) - pos[PRE_IDX_W-1:0];
    assign bit_idx     = pos[POS_W-1:1];
    assign in_preamble = pos < POS_W'(PRE_CELLS);

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= 1'b0;
        end else if (cell_en) begin
            if (in_preamble) begin
                line_q <= pre[pre_idx];
            end else if (!pos[0]) begin
                line_q <= !line_q;
            end else if (bits[bit_idx]) begin
                line_q <= !line_q;
            end
        end
    end

    assign line = line_q;

endmodule

// File: rtl/spdif_tx.sv
module spdif_tx
    import spdif_pkg::*;
#(
    parameter int BLOCK_FRAMES = 192
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cell_en,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [SAMPLE_W-1:0] in_left,
    input  logic [SAMPLE_W-1:0] in_right,
    input  logic                mute,
    output logic                line_out
);

    localparam int BLOCK_SUBFRAMES = 2 * BLOCK_FRAMES;

    pair_t                  in_pair;
    pair_t                  slot_pair;
    logic                   slot_full;
    logic [POS_W-1:0]       pos;
    logic                   right_ch;
    pre_kind_e              kind;
    logic                   sf_start;
    logic                   frame_start;
    pair_t                  act_pair_q;
    logic                   act_valid_q;
    logic                   mute_q;
    sf_payload_t            payload;
    logic [BITS_PER_SF-1:0] bits;

    assign in_pair = '{right: in_right, left: in_left};

    spdif_input_slot u_slot (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_pair   (in_pair),
        .take      (frame_start),
        .slot_pair (slot_pair),
        .slot_full (slot_full)
    );

    spdif_frame_ctl #(
        .BLOCK_SUBFRAMES (BLOCK_SUBFRAMES)
    ) u_ctl (
        .clk         (clk),
        .rst         (rst),
        .cell_en     (cell_en),
        .pos         (pos),
        .right_ch    (right_ch),
        .kind        (kind),
        .sf_start    (sf_start),
        .frame_start (frame_start)
    );

    // active frame: loaded at left start, mute captured per subframe
    always_ff @(posedge clk) begin
        if (rst) begin
            act_pair_q  <= '0;
            act_valid_q <= 1'b0;
            mute_q      <= 1'b0;
        end else begin
            if (frame_start) begin
                act_valid_q <= slot_full;
                act_pair_q  <= slot_full ? slot_pair : '0;
            end
            if (sf_start) begin
                mute_q <= mute;
            end
        end
    end

    assign payload.pcm     = right_ch ? act_pair_q.right : act_pair_q.left;
    assign payload.invalid = mute_q || !act_valid_q;
    assign bits            = pack_bits(payload);

    spdif_cell_enc u_enc (
        .clk     (clk),
        .rst     (rst),
        .cell_en (cell_en),
        .pos     (pos),
        .kind    (kind),
        .bits    (bits),
        .line    (line_out)
    );

endmodule

// File: rtl/spdif_tx_chk.sv
module spdif_tx_chk (
    input logic clk,
    input logic rst,
    input logic cell_en,
    input logic in_valid,
    input logic in_ready,
    input logic line_out
);

    logic [5:0] cpos;

    always_ff @(posedge clk) begin
        if (rst) begin
            cpos <= '0;
        end else if (cell_en) begin
            cpos <= cpos + 1'b1;
        end
    end

    AST_LINE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cell_en |=> $stable(line_out)); // R1

    AST_PREAMBLE_LEAD: assert property (@(posedge clk) disable iff (rst)
        (cell_en && cpos == 6'd0) |=> line_out); // R3

    AST_SF_END_LOW: assert property (@(posedge clk) disable iff (rst)
        (cell_en && cpos == 6'd0) |-> !line_out); // R6

    AST_BMC_BIT_START: assert property (@(posedge clk) disable iff (rst)
        (cell_en && cpos >= 6'd8 && !cpos[0]) |=> (line_out != $past(line_out))); // R5

    AST_SLOT_FILLS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready); // R10

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (!line_out && in_ready)); // R9

endmodule

bind spdif_tx spdif_tx_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cell_en  (cell_en),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .line_out (line_out)
);

// File: tb/spdif_tx_bench.sv
module spdif_tx_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cell_en = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_left = '0;
    logic [15:0] in_right = '0;
    logic        mute = 1'b0;
    logic        line_out;

    always #5 clk = ~clk;

    spdif_tx u_spdif_tx (
        .clk      (clk),
        .rst      (rst),
        .cell_en  (cell_en),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_left  (in_left),
        .in_right (in_right),
        .mute     (mute),
        .line_out (line_out)
    );

    int checks = 0;
    int bad = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pre_pat(input int kind);
        if (kind == 0) return 8'b1110_1000;
        if (kind == 2) return 8'b1110_0100;
        return 8'b1110_0010;
    endfunction

    // expected 64 cells of one subframe, cell i in bit i
    function automatic logic [63:0] make_cells(input int kind, input logic [15:0] s, input bit v);
        logic [63:0] c;
        logic [7:0]  p;
        bit lvl, c0, c1, b;
        p = pre_pat(kind);
        for (int i = 0; i < 8; i++) c[i] = p[7-i];
        lvl = 1'b0;
        for (int k = 4; k < 32; k++) begin
            if (k == 4) b = (^s) ^ v;
            else if (k >= 12 && k < 28) b = s[k-12];
            else if (k == 28) b = v;
            else b = 1'b0;
            c0 = !lvl;
            c1 = b ? !c0 : c0;
            c[2*k] = c0;
            c[2*k+1] = c1;
            lvl = c1;
        end
        return c;
    endfunction

    typedef struct {
        logic [15:0] s;
        bit          v;
        bit          empty;
    } rec_t;
    rec_t rec_q[$];

    // reference model, advanced on each rising edge
    int          m_pos = 0;
    int          m_last = 0;
    bit          m_ch = 0;
    int          m_sf = 0;
    bit          m_full = 0;
    logic [15:0] m_hl = '0, m_hr = '0;
    logic [15:0] m_al = '0, m_ar = '0;
    bit          m_av = 0;
    bit          m_empty = 0;
    logic [63:0] m_cells = '0;
    bit          exp_line = 0;
    bit          m_live = 0;
    bit          strobe_q = 0;
    bit          m_acc;
    rec_t        r;

    always @(posedge clk) begin
        if (rst) begin
            m_pos = 0; m_ch = 0; m_sf = 0; m_full = 0; m_av = 0;
            exp_line = 0; m_live = 0; strobe_q = 0;
            rec_q.delete();
        end else begin
            m_live = 1;
            m_acc = in_valid && !m_full;
            strobe_q = cell_en;
            if (cell_en) begin
                if (m_pos == 0) begin
                    if (!m_ch) begin
                        m_av = m_full;
                        m_empty = !m_full;
                        m_al = m_full ? m_hl : 16'h0;
                        m_ar = m_full ? m_hr : 16'h0;
                        m_full = 0;
                    end
                    r.s = m_ch ? m_ar : m_al;
                    r.v = mute || !m_av;
                    r.empty = m_empty;
                    m_cells = make_cells((m_sf == 0) ? 0 : (m_ch ? 2 : 1), r.s, r.v);
                    rec_q.push_back(r);
                end
                exp_line = m_cells[m_pos];
                m_last = m_pos;
                m_pos++;
                if (m_pos == 64) begin
                    m_pos = 0;
                    m_ch = !m_ch;
                    m_sf = (m_sf + 1) % 384;
                end
            end
            if (m_acc) begin
                m_hl = in_left;
                m_hr = in_right;
                m_full = 1;
            end
        end
    end

    // per-cycle comparison and an independent line decoder
    bit          cap [64];
    int          d_pos = 0;
    int          d_sf = 0;
    string       req;

    always @(negedge clk) begin
        if (!m_live) begin
            d_pos = 0;
            d_sf = 0;
        end else begin
            if (!strobe_q) req = "R1";
            else if (m_last < 8) req = "R3";
            else if (m_last < 10) req = "R6";
            else if (m_last >= 24 && m_last < 56) req = "R2";
            else if (m_last == 56 || m_last == 57) req = "R7";
            else req = "R5";
            chk(line_out === exp_line, req, "line cell", int'(line_out), int'(exp_line));
            chk(in_ready === !m_full, "R10", "in_ready", int'(in_ready), int'(!m_full));
            if (strobe_q) begin
                cap[d_pos] = line_out;
                d_pos++;
                if (d_pos == 64) begin
                    logic [7:0]  pobs;
                    logic [31:0] db;
                    logic [15:0] ds;
                    bit          trans_ok;
                    bit          is_b;
                    rec_t        rr;
                    for (int i = 0; i < 8; i++) pobs[7-i] = cap[i];
                    trans_ok = 1;
                    db = '0;
                    for (int k = 4; k < 32; k++) begin
                        if (cap[2*k] == cap[2*k-1]) trans_ok = 0;
                        db[k] = cap[2*k] != cap[2*k+1];
                    end
                    for (int i = 0; i < 16; i++) ds[i] = db[12+i];
                    is_b = (pobs == 8'b1110_1000);
                    chk(is_b == ((d_sf % 384) == 0), "R4", "B position",
                        int'(is_b), int'((d_sf % 384) == 0));
                    chk(pobs == pre_pat((d_sf % 384 == 0) ? 0 : ((d_sf % 2) ? 2 : 1)),
                        "R3", "preamble", int'(pobs),
                        int'(pre_pat((d_sf % 384 == 0) ? 0 : ((d_sf % 2) ? 2 : 1))));
                    chk(trans_ok, "R5", "bit start transitions", int'(trans_ok), 1);
                    chk(((^db[30:4]) == 1'b0) && (db[31] == 1'b0), "R6", "parity",
                        int'(db[31:4]), 0);
                    if (rec_q.size() > 0) begin
                        rr = rec_q.pop_front();
                        chk(ds == rr.s, "R2", "decoded sample", int'(ds), int'(rr.s));
                        chk(db[28] == rr.v, rr.empty ? "R8" : "R7", "V flag",
                            int'(db[28]), int'(rr.v));
                    end else begin
                        chk(0, "R2", "subframe record missing", 0, 1);
                    end
                    d_pos = 0;
                    d_sf++;
                end
            end
        end
    end

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    endtask

    initial begin
        bit rdy_snap;
        bit acc;
        bit gap;
        rdy_snap = 0;
        repeat (3) @(negedge clk);
        chk(line_out === 1'b0, "R9", "line in reset", int'(line_out), 0);
        chk(in_ready === 1'b1, "R9", "ready in reset", int'(in_ready), 1);
        for (int n = 0; n < 150000; n++) begin
            @(negedge clk);
            acc = in_valid && rdy_snap && !rst;
            if (n == 60002) begin
                chk(line_out === 1'b0, "R9", "line after mid reset", int'(line_out), 0);
                chk(in_ready === 1'b1, "R9", "ready after mid reset", int'(in_ready), 1);
            end
            rst = (n >= 60000 && n < 60003);
            cell_en = (n % 3 != 2);
            gap = (n >= 20000 && n < 24000) || (n >= 90000 && n < 91500);
            if (rst || gap) begin
                in_valid = 1'b0;
            end else if (acc || !in_valid) begin
                if ($urandom % 8 != 0) begin
                    in_valid = 1'b1;
                    in_left  = 16'($urandom);
                    in_right = 16'($urandom);
                end else begin
                    in_valid = 1'b0;
                end
            end
            if (n % 700 == 0) mute = ($urandom % 4 == 0);
            rdy_snap = in_ready;
        end
        done = 1;
        finish_run();
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            checks++;
            bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

endmodule